// File: doc/BRIEF.md
# Prioritized Interrupt Hub

This block gathers 32 interrupt lines and presents two request outputs to a processor: a normal-class request and a fast-class request. Each line has its own configuration word, which chooses edge or level sensing, the class it feeds and a 5-bit priority. A line that is asserted becomes pending. If a pending line is also unmasked and routed to a class, that class's output raises. At that moment the hub latches the winning line number, which is the lowest priority value, with ties going to the higher line number.

Software uses a 32-bit register port. It reads the latched winner code of a class to find the source. For an edge-sensed line, that read also acknowledges the line. Writing the control register starts a new agreement for a class: the class output drops, and the class can fire again for whatever is still pending and unmasked. Software can clear pending bits by writing the pending register. A level-sensed line whose input is still high keeps its pending bit. Software can also inject a request on a line through the trigger register.

The register port accepts one access every cycle and has no back-pressure: there is no ready signal, and the block never stalls. For every read it returns exactly one response one cycle later, flagged by `rsp_valid`. Writes return no response.

Top module: `pri_irq_hub`

## Requirements
- R1: A line's configuration word is at byte offset 0x1C + 4*n. It holds priority in bits [6:2], sense in bit 1 (1 = level, 0 = edge) and fast routing in bit 0. It reads back in that layout with all other bits zero.
- R2: In level mode, a rising input sets the line's pending bit, and a falling input clears it.
- R3: In edge mode, an assertion sets the pending bit only if the line's input state was low and the line was not already pending. The bit stays set when the input falls.
- R4: A write to the pending register (0x00) ANDs it with the written data. A level-mode line whose input is high keeps its pending bit.
- R5: A line with its bit set in the mask register (0x04) takes no part in arbitration. Changing the mask re-evaluates both classes on the following cycle.
- R6: The winner is the pending, unmasked line of the class with the lowest priority value. Among equal priorities the higher line number wins.
- R7: Lines with fast routing set feed only the fast output and the fast winner code (0x14). All other lines feed only the normal output and the normal winner code (0x10).
- R8: A class output stays high and its winner code stays fixed until a control write (0x18) with bit 0 (normal) or bit 1 (fast). After that write the output is low for at least one cycle, and it then refires if the class still has a candidate.
- R9: Reading a winner code register returns the latched line number. The read clears that line's pending bit if the line is in edge mode, and leaves a level-mode line pending.
- R10: A write to the trigger register (0x9C) asserts a request on only the lowest-numbered set bit of the data. Reads of 0x9C return 0.
- R11: Writes to the winner code registers, to undefined offsets and to addresses with bits [1:0] nonzero change nothing. Such reads, and control reads, return 0.
- R12: After reset the mask is all ones and both outputs are low. Pending, input state, sense, routing, priority and both winner codes are zero.
- R13: Every read returns `rsp_valid` with its data on the next cycle. `rsp_valid` is low after a write or an idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Interrupt lines, sampled on every clock edge |
| reg_valid | input | 1 | Register access request this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data is valid |
| rsp_rdata | output | 32 | Read data |
| irq_norm | output | 1 | Normal-class request |
| irq_fast | output | 1 | Fast-class request |

## Verification
The level-hold property assumes that `irq_in` is synchronous to `clk`, so that a line seen high both in its stored input state and on the pin cannot fall at the next edge. The bench meets this by changing inputs only on falling clock edges. The sticky-output and drop checks assume that software selects the control register only through the aligned address 0x18. The routing checks assume a winner code always names a line in range. The bench uses only aligned addresses except in the deliberate misaligned case, and it holds reset across several edges before the first access.

// File: rtl/ih_pkg.sv
package ih_pkg;

  // Register kinds produced by the address decoder
  typedef enum logic [2:0] {
    RK_NONE,
    RK_PEND,
    RK_MASK,
    RK_WIN_N,
    RK_WIN_F,
    RK_CTRL,
    RK_CFG,
    RK_SWT
  } ih_reg_e;

  // Word indexes (byte offset / 4) of the fixed registers
  localparam int unsigned WIDX_PEND  = 0;
  localparam int unsigned WIDX_MASK  = 1;
  localparam int unsigned WIDX_WIN_N = 4;
  localparam int unsigned WIDX_WIN_F = 5;
  localparam int unsigned WIDX_CTRL  = 6;
  localparam int unsigned WIDX_CFG0  = 7;

  // Class numbering, also the bit of the control word for each class
  localparam int unsigned CLS_NORM = 0;
  localparam int unsigned CLS_FAST = 1;
  localparam int unsigned N_CLS    = 2;

endpackage

// File: rtl/ih_reg_decode.sv
module ih_reg_decode
  import ih_pkg::*;
#(
  parameter int unsigned N_LINES = 32,
  parameter int unsigned ADDR_W  = 8,
  localparam int unsigned IDX_W  = $clog2(N_LINES),
  localparam int unsigned WIDX_W = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr,
  output ih_reg_e           kind,
  output logic [IDX_W-1:0]  line
);

  localparam int unsigned WIDX_SWT = WIDX_CFG0 + N_LINES;

  logic [WIDX_W-1:0] widx;
  logic              aligned;

  assign widx    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    kind = RK_NONE;
    line = '0;
    if (aligned) begin
      if (widx == WIDX_W'(WIDX_PEND)) begin
        kind = RK_PEND;
      end else if (widx == WIDX_W'(WIDX_MASK)) begin
        kind = RK_MASK;
      end else if (widx == WIDX_W'(WIDX_WIN_N)) begin
        kind = RK_WIN_N;
      end else if (widx == WIDX_W'(WIDX_WIN_F)) begin
        kind = RK_WIN_F;
      end else if (widx == WIDX_W'(WIDX_CTRL)) begin
        kind = RK_CTRL;
      end else if (widx >= WIDX_W'(WIDX_CFG0) && widx < WIDX_W'(WIDX_SWT)) begin
        kind = RK_CFG;
        line = IDX_W'(widx - WIDX_W'(WIDX_CFG0));
      end else if (widx == WIDX_W'(WIDX_SWT)) begin
        kind = RK_SWT;
      end
    end
  end

endmodule

// File: rtl/ih_line_state.sv
module ih_line_state #(
  parameter int unsigned N_LINES = 32,
  parameter int unsigned PRIO_W  = 5,
  localparam int unsigned IDX_W  = $clog2(N_LINES),
  localparam int unsigned CFG_W  = PRIO_W + 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_LINES-1:0]        irq_in,
  input  logic [N_LINES-1:0]        sw_hot,
  input  logic                      pend_we,
  input  logic [N_LINES-1:0]        pend_wdata,
  input  logic                      ack_en,
  input  logic [IDX_W-1:0]          ack_line,
  input  logic                      cfg_we,
  input  logic [IDX_W-1:0]          cfg_line,
  input  logic [CFG_W-1:0]          cfg_wdata,
  output logic [N_LINES-1:0]        pend_q,
  output logic [N_LINES-1:0]        inp_q,
  output logic [N_LINES-1:0]        lvl_q,
  output logic [N_LINES-1:0]        fast_q,
  output logic [N_LINES*PRIO_W-1:0] prio_flat
);

  logic [N_LINES-1:0] pin_q;
  logic [N_LINES-1:0] assert_ev, deassert_ev;
  logic [N_LINES-1:0] set_v, keep_v, ack_v, lvl_clr;
  logic [N_LINES-1:0] inp_d, pend_d;
  logic [PRIO_W-1:0]  prio_q [N_LINES];

  // Request events: pin edges plus one-hot software injection
  assign assert_ev   = (irq_in & ~pin_q) | sw_hot;
  assign deassert_ev = pin_q & ~irq_in & ~sw_hot;

  // A rising request becomes pending when not already pending;
  // edge-sensed lines additionally need a low input state before.
  assign set_v   = assert_ev & ~pend_q & (lvl_q | ~inp_q);
  assign lvl_clr = deassert_ev & lvl_q;

  // Software clear, with level lines still asserted protected
  assign keep_v = pend_we ? (pend_wdata | (inp_q & lvl_q)) : '1;

  // Winner-code read acknowledges an edge-sensed line
  always_comb begin
    ack_v = '0;
    if (ack_en) ack_v[ack_line] = ~lvl_q[ack_line];
  end

  assign inp_d  = (inp_q | assert_ev) & ~deassert_ev;
  assign pend_d = ((pend_q & keep_v & ~ack_v) | set_v) & ~lvl_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= '0;
      inp_q  <= '0;
      pend_q <= '0;
    end else begin
      pin_q  <= irq_in;
      inp_q  <= inp_d;
      pend_q <= pend_d;
    end
  end

  // Per-line configuration: priority, sense and routing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      fast_q <= '0;
      for (int i = 0; i < N_LINES; i++) prio_q[i] <= '0;
    end else if (cfg_we) begin
      for (int i = 0; i < N_LINES; i++) begin
        if (cfg_line == IDX_W'(i)) begin
          fast_q[i] <= cfg_wdata[0];
          lvl_q[i]  <= cfg_wdata[1];
          prio_q[i] <= cfg_wdata[2 +: PRIO_W];
        end
      end
    end
  end

  for (genvar g = 0; g < N_LINES; g++) begin : g_prio
    assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q[g];
  end

endmodule

// File: rtl/ih_prio_sort.sv
module ih_prio_sort #(
  parameter int unsigned N_LINES = 32,
  parameter int unsigned PRIO_W  = 5,
  localparam int unsigned IDX_W  = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0]        req,
  input  logic [N_LINES*PRIO_W-1:0] prio_flat,
  output logic                      any,
  output logic [IDX_W-1:0]          idx
);

  // Binary tree, N_LINES a power of two. Node k has children 2k and
  // 2k+1; leaves sit at N_LINES+i, so right children hold higher lines.
  localparam int unsigned NODES = 2 * N_LINES;

  logic [NODES-1:1]  nv;
  logic [PRIO_W-1:0] np [2:NODES-1];
  logic [IDX_W-1:0]  ni [1:NODES-1];

  for (genvar i = 0; i < N_LINES; i++) begin : g_leaf
    assign nv[N_LINES+i] = req[i];
    assign np[N_LINES+i] = prio_flat[i*PRIO_W +: PRIO_W];
    assign ni[N_LINES+i] = IDX_W'(i);
  end

  for (genvar k = 1; k < N_LINES; k++) begin : g_node
    logic take_r;
    // Lower value wins; an equal value goes to the higher line
    assign take_r = nv[2*k+1] && (!nv[2*k] || (np[2*k+1] <= np[2*k]));
    assign nv[k]  = nv[2*k] | nv[2*k+1];
    assign ni[k]  = take_r ? ni[2*k+1] : ni[2*k];
    if (k > 1) begin : g_prio
      assign np[k] = take_r ? np[2*k+1] : np[2*k];
    end
  end

  assign any = nv[1];
  assign idx = ni[1];

endmodule

// File: rtl/ih_class_arb.sv
module ih_class_arb #(
  parameter int unsigned N_LINES = 32,
  parameter int unsigned PRIO_W  = 5,
  localparam int unsigned IDX_W  = $clog2(N_LINES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_LINES-1:0]        active,
  input  logic [N_LINES*PRIO_W-1:0] prio_flat,
  input  logic                      new_agr,
  output logic                      irq_o,
  output logic [IDX_W-1:0]          win_o
);

  logic             cand_any;
  logic [IDX_W-1:0] cand_idx;

  ih_prio_sort #(
    .N_LINES (N_LINES),
    .PRIO_W  (PRIO_W)
  ) u_sort (
    .req       (active),
    .prio_flat (prio_flat),
    .any       (cand_any),
    .idx       (cand_idx)
  );

  // Output low means the class is armed for its next agreement
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      win_o <= '0;
    end else if (new_agr) begin
      irq_o <= 1'b0;
    end else if (!irq_o && cand_any) begin
      irq_o <= 1'b1;
      win_o <= cand_idx;
    end
  end

endmodule

// File: rtl/pri_irq_hub.sv
module pri_irq_hub
  import ih_pkg::*;
#(
  parameter int unsigned N_LINES = 32,
  parameter int unsigned PRIO_W  = 5,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [31:0]        irq_in,
  input  logic               reg_valid,
  input  logic               reg_write,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               irq_norm,
  output logic               irq_fast
);

  localparam int unsigned IDX_W = $clog2(N_LINES);
  localparam int unsigned CFG_W = PRIO_W + 2;

  ih_reg_e            kind;
  logic [IDX_W-1:0]   acc_line;
  logic               wr_en, rd_en;
  logic [N_LINES-1:0] wlow, sw_hot;
  logic [N_LINES-1:0] pend_q, inp_q, lvl_q, fast_q, mask_q;
  logic [N_LINES*PRIO_W-1:0] prio_flat;
  logic [N_LINES-1:0] active [N_CLS];
  logic [N_CLS-1:0]   irq_q, new_agr;
  logic [IDX_W-1:0]   win_q [N_CLS];
  logic [IDX_W-1:0]   win_norm, win_fast;
  logic               ack_en;
  logic [IDX_W-1:0]   ack_line;
  logic [DATA_W-1:0]  rd_mux;

  ih_reg_decode #(
    .N_LINES (N_LINES),
    .ADDR_W  (ADDR_W)
  ) u_dec (
    .addr (reg_addr),
    .kind (kind),
    .line (acc_line)
  );

  assign wr_en = reg_valid &&  reg_write;
  assign rd_en = reg_valid && !reg_write;

  // Software trigger keeps only the lowest set bit of the data
  assign wlow   = reg_wdata[N_LINES-1:0];
  assign sw_hot = (wr_en && kind == RK_SWT) ? (wlow & (~wlow + 1'b1)) : '0;

  // Winner-code reads acknowledge the latched line
  assign win_norm = win_q[CLS_NORM];
  assign win_fast = win_q[CLS_FAST];
  assign ack_en   = rd_en && (kind == RK_WIN_N || kind == RK_WIN_F);
  assign ack_line = (kind == RK_WIN_F) ? win_fast : win_norm;

  ih_line_state #(
    .N_LINES (N_LINES),
    .PRIO_W  (PRIO_W)
  ) u_lines (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_in     (irq_in[N_LINES-1:0]),
    .sw_hot     (sw_hot),
    .pend_we    (wr_en && kind == RK_PEND),
    .pend_wdata (wlow),
    .ack_en     (ack_en),
    .ack_line   (ack_line),
    .cfg_we     (wr_en && kind == RK_CFG),
    .cfg_line   (acc_line),
    .cfg_wdata  (reg_wdata[CFG_W-1:0]),
    .pend_q     (pend_q),
    .inp_q      (inp_q),
    .lvl_q      (lvl_q),
    .fast_q     (fast_q),
    .prio_flat  (prio_flat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (wr_en && kind == RK_MASK) begin
      mask_q <= wlow;
    end
  end

  // One arbiter per class; the control word bit equals the class number
  for (genvar c = 0; c < N_CLS; c++) begin : g_cls
    if (c == CLS_FAST) begin : g_route
      assign active[c] = pend_q & ~mask_q & fast_q;
    end else begin : g_route
      assign active[c] = pend_q & ~mask_q & ~fast_q;
    end
    assign new_agr[c] = wr_en && (kind == RK_CTRL) && reg_wdata[c];

    ih_class_arb #(
      .N_LINES (N_LINES),
      .PRIO_W  (PRIO_W)
    ) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (active[c]),
      .prio_flat (prio_flat),
      .new_agr   (new_agr[c]),
      .irq_o     (irq_q[c]),
      .win_o     (win_q[c])
    );
  end

  assign irq_norm = irq_q[CLS_NORM];
  assign irq_fast = irq_q[CLS_FAST];

  // Read data, registered with the response strobe
  always_comb begin
    rd_mux = '0;
    case (kind)
      RK_PEND:  rd_mux = DATA_W'(pend_q);
      RK_MASK:  rd_mux = DATA_W'(mask_q);
      RK_WIN_N: rd_mux = DATA_W'(win_norm);
      RK_WIN_F: rd_mux = DATA_W'(win_fast);
      RK_CFG:   rd_mux = DATA_W'({prio_flat[acc_line*PRIO_W +: PRIO_W],
                                  lvl_q[acc_line], fast_q[acc_line]});
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_en;
      rsp_rdata <= rd_en ? rd_mux : '0;
    end
  end

endmodule

// File: rtl/ih_hub_chk.sv
module ih_hub_chk #(
  parameter int unsigned N_LINES = 32,
  parameter int unsigned ADDR_W  = 8,
  localparam int unsigned IDX_W  = $clog2(N_LINES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_valid,
  input logic               reg_write,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [1:0]         ctrl_bits,
  input logic               rsp_valid,
  input logic [N_LINES-1:0] irq_in,
  input logic               irq_norm,
  input logic               irq_fast,
  input logic [N_LINES-1:0] pend_q,
  input logic [N_LINES-1:0] inp_q,
  input logic [N_LINES-1:0] lvl_q,
  input logic [N_LINES-1:0] fast_q,
  input logic [N_LINES-1:0] mask_q,
  input logic [IDX_W-1:0]   win_fast
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(24);

  logic ctrl_n, ctrl_f;
  logic [N_LINES-1:0] cand_f_prev, cand_n_prev;

  assign ctrl_n = reg_valid && reg_write && (reg_addr == CTRL_ADDR) && ctrl_bits[0];
  assign ctrl_f = reg_valid && reg_write && (reg_addr == CTRL_ADDR) && ctrl_bits[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_f_prev <= '0;
      cand_n_prev <= '0;
    end else begin
      cand_f_prev <= pend_q & ~mask_q &  fast_q;
      cand_n_prev <= pend_q & ~mask_q & ~fast_q;
    end
  end

  // R8
  ctrl_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_n |=> !irq_norm);

  // R8
  sticky_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_fast && !ctrl_f) |=> irq_fast);

  // R4
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_q & lvl_q & inp_q & irq_in) & ~pend_q) == '0));

  // R7
  fast_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_fast) |-> cand_f_prev[win_fast]);

  // R5
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_norm) |-> (cand_n_prev != '0));

  // R13
  rsp_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !reg_write) |=> rsp_valid);

  // R13
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_valid && !reg_write) |=> !rsp_valid);

endmodule

bind pri_irq_hub ih_hub_chk #(
  .N_LINES (N_LINES),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_valid (reg_valid),
  .reg_write (reg_write),
  .reg_addr  (reg_addr),
  .ctrl_bits (reg_wdata[1:0]),
  .rsp_valid (rsp_valid),
  .irq_in    (irq_in[N_LINES-1:0]),
  .irq_norm  (irq_norm),
  .irq_fast  (irq_fast),
  .pend_q    (pend_q),
  .inp_q     (inp_q),
  .lvl_q     (lvl_q),
  .fast_q    (fast_q),
  .mask_q    (mask_q),
  .win_fast  (win_fast)
);

// File: tb/pri_irq_hub_bench.sv
module pri_irq_hub_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        reg_valid = 1'b0;
  logic        reg_write = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        irq_norm, irq_fast;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pri_irq_hub u_pri_irq_hub (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .reg_valid (reg_valid),
    .reg_write (reg_write),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .irq_norm  (irq_norm),
    .irq_fast  (irq_fast)
  );

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_valid = 1'b0;
    d = rsp_valid ? rsp_rdata : 32'hxxxx_xxxx;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    rd(a, v);
    chk(v, exp, tag);
  endtask

  task automatic set_pin(input int n, input logic v);
    @(negedge clk);
    irq_in[n] = v;
  endtask

  function automatic logic [7:0] cfg_addr(input int n);
    return 8'(28 + 4 * n);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    tick(4);
    rst_n = 1'b1;
    tick(1);

    // R12 reset state
    chk({31'd0, irq_norm}, 0, "R12 irq_norm");
    chk({31'd0, irq_fast}, 0, "R12 irq_fast");
    chk({31'd0, rsp_valid}, 0, "R13 rsp_valid idle");
    rd_chk(8'h00, 32'h0, "R12 pending");
    rd_chk(8'h04, 32'hFFFF_FFFF, "R12 mask");
    rd_chk(8'h10, 32'h0, "R12 normal winner");
    rd_chk(8'h14, 32'h0, "R12 fast winner");
    for (int n = 0; n < 32; n += 7) rd_chk(cfg_addr(n), 32'h0, "R12 config");

    // R13 a write returns no response
    wr(8'h04, 32'hFFFF_FFFF);
    chk({31'd0, rsp_valid}, 0, "R13 no response on write");

    // R1 configuration sweep, arithmetic pattern with junk upper bits
    for (int n = 0; n < 32; n++) wr(cfg_addr(n), 32'hDEAD_BE00 | 32'((n * 13 + 5) & 8'h7F));
    for (int n = 0; n < 32; n++) rd_chk(cfg_addr(n), 32'((n * 13 + 5) & 8'h7F), "R1 config readback");

    // All lines level, normal, priority 0
    for (int n = 0; n < 32; n++) wr(cfg_addr(n), 32'h2);

    // R2 / R4 level sweep over every line
    for (int n = 0; n < 32; n++) begin
      set_pin(n, 1'b1);
      tick(2);
      rd_chk(8'h00, 32'(1) << n, "R2 level set");
      wr(8'h00, 32'h0);
      rd_chk(8'h00, 32'(1) << n, "R4 level held while input high");
      set_pin(n, 1'b0);
      tick(2);
      rd_chk(8'h00, 32'h0, "R2 level cleared on fall");
    end

    // R3 edge behaviour on line 5
    wr(cfg_addr(5), 32'h0);
    set_pin(5, 1'b1); tick(2);
    rd_chk(8'h00, 32'h20, "R3 edge set");
    set_pin(5, 1'b0); tick(2);
    rd_chk(8'h00, 32'h20, "R3 edge stays after fall");
    wr(8'h00, ~32'h20);
    rd_chk(8'h00, 32'h0, "R4 edge cleared by write");
    set_pin(5, 1'b1); tick(2);
    rd_chk(8'h00, 32'h20, "R3 edge set again");
    wr(8'h00, 32'h0);
    rd_chk(8'h00, 32'h0, "R4 edge cleared while input high");
    tick(3);
    rd_chk(8'h00, 32'h0, "R3 no re-set while held high");
    set_pin(5, 1'b0);

    // R6 / R8 priority and sticky output
    wr(cfg_addr(3), 32'h2A);   // priority 10, level
    wr(cfg_addr(20), 32'h12);  // priority 4, level
    wr(cfg_addr(25), 32'h12);  // priority 4, level
    wr(8'h04, 32'h0);
    set_pin(3, 1'b1); tick(3);
    chk({31'd0, irq_norm}, 1, "R6 normal request");
    rd_chk(8'h10, 32'd3, "R6 single winner");
    set_pin(20, 1'b1); set_pin(25, 1'b1); tick(3);
    chk({31'd0, irq_norm}, 1, "R8 output held");
    rd_chk(8'h10, 32'd3, "R8 winner held");
    wr(8'h18, 32'h1);
    chk({31'd0, irq_norm}, 0, "R8 drop after control");
    tick(2);
    chk({31'd0, irq_norm}, 1, "R8 refire");
    rd_chk(8'h10, 32'd25, "R6 tie goes to higher line");
    set_pin(25, 1'b0);
    wr(8'h18, 32'h1); tick(2);
    rd_chk(8'h10, 32'd20, "R6 lower value beats line 3");
    set_pin(20, 1'b0);
    wr(8'h18, 32'h1); tick(2);
    rd_chk(8'h10, 32'd3, "R6 remaining line");

    // R5 mask
    wr(8'h04, 32'hFFFF_FFFF);
    chk({31'd0, irq_norm}, 1, "R8 held under mask");
    wr(8'h18, 32'h1); tick(3);
    chk({31'd0, irq_norm}, 0, "R5 masked line no request");
    set_pin(20, 1'b1); tick(2);
    chk({31'd0, irq_norm}, 0, "R5 still masked");
    wr(8'h04, ~(32'(1) << 20)); tick(1);
    chk({31'd0, irq_norm}, 1, "R5 unmask re-evaluates");
    rd_chk(8'h10, 32'd20, "R5 winner after unmask");
    set_pin(3, 1'b0); set_pin(20, 1'b0);
    wr(8'h18, 32'h1); tick(2);
    chk({31'd0, irq_norm}, 0, "R2 nothing pending after falls");

    // R7 fast routing, R9 level line not acknowledged
    wr(cfg_addr(10), 32'h3);
    wr(8'h04, ~(32'(1) << 10));
    set_pin(10, 1'b1); tick(3);
    chk({31'd0, irq_fast}, 1, "R7 fast request");
    chk({31'd0, irq_norm}, 0, "R7 normal untouched");
    rd_chk(8'h14, 32'd10, "R7 fast winner");
    rd_chk(8'h00, 32'h400, "R9 level line stays pending");
    set_pin(10, 1'b0);
    wr(8'h18, 32'h3); tick(2);
    chk({31'd0, irq_fast}, 0, "R8 fast dropped");

    // R9 edge acknowledge through winner read
    wr(cfg_addr(12), 32'h1);
    wr(8'h04, ~(32'(1) << 12));
    set_pin(12, 1'b1); set_pin(12, 1'b0); tick(2);
    chk({31'd0, irq_fast}, 1, "R9 edge fast request");
    rd_chk(8'h14, 32'd12, "R9 winner code");
    rd_chk(8'h00, 32'h0, "R9 edge acknowledged");
    wr(8'h18, 32'h2);

    // R10 software trigger
    wr(cfg_addr(7), 32'h0);
    wr(cfg_addr(9), 32'h0);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h9C, (32'(1) << 30) | (32'(1) << 9) | (32'(1) << 7));
    rd_chk(8'h00, 32'h80, "R10 lowest bit only");
    rd_chk(8'h9C, 32'h0, "R10 trigger reads zero");
    wr(8'h00, 32'h0);
    wr(8'h9C, 32'h0);
    rd_chk(8'h00, 32'h0, "R10 zero data no request");

    // R11 ignored accesses
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h10, 32'h0000_1234);
    wr(8'h14, 32'h0000_0003);
    wr(8'h1D, 32'h0000_007F);
    rd_chk(cfg_addr(0), 32'h2, "R11 misaligned write ignored");
    rd_chk(8'h0C, 32'h0, "R11 undefined reads zero");
    rd_chk(8'hA0, 32'h0, "R11 beyond map reads zero");
    rd_chk(8'h18, 32'h0, "R11 control reads zero");
    rd_chk(8'h04, 32'hFFFF_FFFF, "R11 mask untouched");
    rd_chk(8'h00, 32'h0, "R11 pending untouched");
    rd_chk(8'h14, 32'd12, "R11 winner code not writable");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule